// File: doc/BRIEF.md
# Dual-Mode Prioritized Interrupt Controller

The block gathers a set of level-sensitive maskable interrupt sources and one non-maskable pin, and presents the processor with a single registered request. Alongside the request it gives the index of the winning source, that source's 3-bit priority level, and a flag that marks a non-maskable request. A small word-wide register file holds one 3-bit priority field per source and a control word. The control word picks the masking scheme and the active edge of the non-maskable pin.

Two masking schemes can be selected at run time. In the global scheme a single CPU mask bit gates every maskable source, and the lowest-numbered pending source wins. In the level scheme a 3-bit CPU mask level is compared against each source's priority. The highest accepted level wins, and the lowest index breaks a tie. The non-maskable pin is synchronised and edge-detected. A detected edge sets a sticky pending flag, which the processor clears with an acknowledge pulse. While that flag is set, the non-maskable request overrides every maskable source.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every priority register and the control word read 0, and irq_o, irq_nmi_o, irq_id_o and irq_lvl_o are all 0.
- R2: Priority register k (bus address k, 0 <= k < ceil(NUM_SRC/4)) reads back the full 16-bit word last written. Source i takes its level from register i/4, bits 4*(i%4)+2 down to 4*(i%4). Addresses that map to nothing read as 0.
- R3: The control word sits at bus address ceil(NUM_SRC/4). Bits 1:0 hold the mode: 2'b10 selects the level scheme and any other value selects the global scheme. Bit 2 is the edge select. Bits 7:3 are spare storage. All eight bits read back as written, bits 15:8 read 0, and the word changes only on a write.
- R4: In the global scheme a maskable source is accepted only while cpu_imask_i is 0. The lowest-index pending source wins whatever its priority field holds, and irq_lvl_o shows that field.
- R5: In the level scheme a pending source is accepted only when its level is strictly greater than cpu_ilvl_i, or when its level is 7. A source at level 0 is never accepted.
- R6: In the level scheme the accepted source with the highest level wins, and among equal levels the lowest index wins.
- R7: The mode values 2'b00, 2'b01 and 2'b11 all behave as the global scheme.
- R8: With edge select 0 a falling edge on nmi_i raises the non-maskable request, and with edge select 1 a rising edge does. The other edge has no effect. irq_nmi_o goes high on the fourth rising clock edge after the pin changes.
- R9: The non-maskable pending state is held until nmi_ack_i is sampled high. The output request drops one cycle after that.
- R10: While the non-maskable request is pending it wins over every maskable source, with irq_o=1, irq_nmi_o=1, irq_id_o=0 and irq_lvl_o=7.
- R11: The outputs are registered and reflect the source and mask inputs one clock edge later. With nothing accepted, irq_o, irq_id_o and irq_lvl_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Word write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| src_i | input | NUM_SRC | Level-sensitive maskable source requests |
| nmi_i | input | 1 | Asynchronous non-maskable pin |
| nmi_ack_i | input | 1 | Clears the non-maskable pending flag |
| cpu_imask_i | input | 1 | CPU global mask bit (global scheme) |
| cpu_ilvl_i | input | 3 | CPU mask level (level scheme) |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_nmi_o | output | 1 | Request is the non-maskable one |
| irq_id_o | output | SRC_W | Index of the winning maskable source |
| irq_lvl_o | output | 3 | Level of the winning request |

## Verification
The bench builds the block with its default of 44 sources and a 4-bit address. That gives eleven priority words, so the last word, which holds sources 40 to 43, is in reach, and so is the control word at address 11 with unused addresses above it. With 44 sources the bench can set sources in the first and last words at the same time. It can therefore check that a high level far up the index range beats lower levels near index 0 in the level scheme, and that the lowest index wins in the global scheme. The 3-bit mask range also lets the bench drive the level-7 override with a mask of 7 and a level-0 source that is never accepted.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LVL_W  = 3;
  localparam int WORD_W = 16;
  localparam int CTRL_W = 8;
  localparam logic [1:0] MODE_LEVEL = 2'b10;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_REGS = 11,
  parameter int ADDR_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [WORD_W-1:0]          wdata_i,
  output logic [WORD_W-1:0]          rdata_o,
  output logic [NUM_REGS*WORD_W-1:0] prio_o,
  output logic [CTRL_W-1:0]          ctrl_o
);
  localparam int CTRL_ADDR = NUM_REGS;

  logic [WORD_W-1:0] prio_q [NUM_REGS];
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) prio_q[r] <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr_i == ADDR_W'(r)) prio_q[r] <= wdata_i;
      if (addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (addr_i == ADDR_W'(r)) rdata_o = prio_q[r];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_o = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign prio_o[g*WORD_W +: WORD_W] = prio_q[g];
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_ctrl_nmi.sv
module irq_ctrl_nmi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  input  logic ack_i,
  output logic pend_o
);
  logic sync1_q, sync2_q, prev_q, pend_q, evt;

  // rise_sel_i=1: rising edge; 0: falling edge
  assign evt = rise_sel_i ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (evt)        pend_q <= 1'b1;  // a new edge beats a same-cycle ack
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctrl_arb.sv
module irq_ctrl_arb
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC  = 44,
  parameter int NUM_REGS = 11,
  parameter int SRC_W    = 6
) (
  input  logic [NUM_SRC-1:0]         src_i,
  input  logic [NUM_REGS*WORD_W-1:0] prio_i,
  input  logic                       mode_lvl_i,
  input  logic                       gmask_i,
  input  logic [LVL_W-1:0]           lmask_i,
  output logic                       hit_o,
  output logic [SRC_W-1:0]           id_o,
  output logic [LVL_W-1:0]           lvl_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_SRC-1:0][LVL_W-1:0] key;
  logic [NUM_SRC-1:0]            acc;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign lvl[i] = prio_i[(i/4)*WORD_W + (i%4)*4 +: LVL_W];
    assign acc[i] = src_i[i] &
                    (mode_lvl_i ? ((lvl[i] > lmask_i) | (lvl[i] == LVL_MAX)) : ~gmask_i);
    assign key[i] = mode_lvl_i ? lvl[i] : '0;
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    logic [LVL_W-1:0] best_key;
    hit_o    = 1'b0;
    id_o     = '0;
    lvl_o    = '0;
    best_key = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (acc[i] && (!hit_o || key[i] > best_key)) begin
        hit_o    = 1'b1;
        id_o     = SRC_W'(i);
        lvl_o    = lvl[i];
        best_key = key[i];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_SRC = 44,
  parameter int ADDR_W  = 4,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [15:0]        bus_wdata_i,
  output logic [15:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               nmi_i,
  input  logic               nmi_ack_i,
  input  logic               cpu_imask_i,
  input  logic [2:0]         cpu_ilvl_i,
  output logic               irq_o,
  output logic               irq_nmi_o,
  output logic [SRC_W-1:0]   irq_id_o,
  output logic [2:0]         irq_lvl_o
);
  localparam int NUM_REGS = (NUM_SRC + 3) / 4;

  logic [NUM_REGS*WORD_W-1:0] prio_flat;
  logic [CTRL_W-1:0]          ctrl_q;
  logic                       nmi_pend;
  logic                       mode_lvl;
  logic                       hit;
  logic [SRC_W-1:0]           win_id;
  logic [LVL_W-1:0]           win_lvl;

  irq_ctrl_regs #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .prio_o  (prio_flat),
    .ctrl_o  (ctrl_q)
  );

  assign mode_lvl = (ctrl_q[1:0] == MODE_LEVEL);

  irq_ctrl_nmi u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (nmi_i),
    .rise_sel_i (ctrl_q[2]),
    .ack_i      (nmi_ack_i),
    .pend_o     (nmi_pend)
  );

  irq_ctrl_arb #(.NUM_SRC(NUM_SRC), .NUM_REGS(NUM_REGS), .SRC_W(SRC_W)) u_arb (
    .src_i      (src_i),
    .prio_i     (prio_flat),
    .mode_lvl_i (mode_lvl),
    .gmask_i    (cpu_imask_i),
    .lmask_i    (cpu_ilvl_i),
    .hit_o      (hit),
    .id_o       (win_id),
    .lvl_o      (win_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      irq_nmi_o <= 1'b0;
      irq_id_o  <= '0;
      irq_lvl_o <= '0;
    end else if (nmi_pend) begin
      irq_o     <= 1'b1;
      irq_nmi_o <= 1'b1;
      irq_id_o  <= '0;
      irq_lvl_o <= LVL_MAX;
    end else begin
      irq_o     <= hit;
      irq_nmi_o <= 1'b0;
      irq_id_o  <= hit ? win_id : '0;
      irq_lvl_o <= hit ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int SRC_W  = 6,
  parameter int CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic              nmi_ack_i,
  input logic              cpu_imask_i,
  input logic [2:0]        cpu_ilvl_i,
  input logic              irq_o,
  input logic              irq_nmi_o,
  input logic [SRC_W-1:0]  irq_id_o,
  input logic [2:0]        irq_lvl_o,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              nmi_pend
);
  logic lvl_mode;
  assign lvl_mode = (ctrl_q[1:0] == 2'b10);

  p_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(ctrl_q));

  p_gmask_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_mode && cpu_imask_i && !nmi_pend) |=> !irq_o);

  p_level_above_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_mode && !nmi_pend) |=>
      (!irq_o || irq_lvl_o > $past(cpu_ilvl_i) || irq_lvl_o == 3'd7));

  p_nmi_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend && !nmi_ack_i) |=> nmi_pend);

  p_nmi_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_pend |=> (irq_o && irq_nmi_o && irq_id_o == '0 && irq_lvl_o == 3'd7));

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (!irq_nmi_o && irq_id_o == '0 && irq_lvl_o == 3'd0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.SRC_W(SRC_W), .CTRL_W(irq_ctrl_pkg::CTRL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .nmi_ack_i   (nmi_ack_i),
  .cpu_imask_i (cpu_imask_i),
  .cpu_ilvl_i  (cpu_ilvl_i),
  .irq_o       (irq_o),
  .irq_nmi_o   (irq_nmi_o),
  .irq_id_o    (irq_id_o),
  .irq_lvl_o   (irq_lvl_o),
  .ctrl_q      (ctrl_q),
  .nmi_pend    (nmi_pend)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int NS = 44;
  localparam int AW = 4;
  localparam int CTRL_A = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_we_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [15:0]   bus_wdata_i = '0;
  logic [15:0]   bus_rdata_o;
  logic [NS-1:0] src_i = '0;
  logic          nmi_i = 1'b0;
  logic          nmi_ack_i = 1'b0;
  logic          cpu_imask_i = 1'b0;
  logic [2:0]    cpu_ilvl_i = '0;
  logic          irq_o, irq_nmi_o;
  logic [5:0]    irq_id_o;
  logic [2:0]    irq_lvl_o;

  irq_ctrl #(.NUM_SRC(NS), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .src_i(src_i),
    .nmi_i(nmi_i), .nmi_ack_i(nmi_ack_i), .cpu_imask_i(cpu_imask_i),
    .cpu_ilvl_i(cpu_ilvl_i), .irq_o(irq_o), .irq_nmi_o(irq_nmi_o),
    .irq_id_o(irq_id_o), .irq_lvl_o(irq_lvl_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int         due;
    bit         nmi_only;
    logic       irq;
    logic       nmi;
    logic [5:0] id;
    logic [2:0] lvl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.nmi_only ? (irq_nmi_o !== e.nmi)
                     : (irq_o !== e.irq || irq_nmi_o !== e.nmi ||
                        irq_id_o !== e.id || irq_lvl_o !== e.lvl)) begin
        errors++;
        $display("FAIL %s: got irq=%0b nmi=%0b id=%0d lvl=%0d exp irq=%0b nmi=%0b id=%0d lvl=%0d",
                 e.tag, irq_o, irq_nmi_o, irq_id_o, irq_lvl_o, e.irq, e.nmi, e.id, e.lvl);
      end
    end
  end

  task automatic push(int due, bit only, logic irq, logic nmi, logic [5:0] id,
                      logic [2:0] lvl, string tag);
    exp_t e;
    e.due = due; e.nmi_only = only; e.irq = irq; e.nmi = nmi;
    e.id = id; e.lvl = lvl; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(logic [NS-1:0] s, logic gm, logic [2:0] lm, logic irq,
                      logic nmi, logic [5:0] id, logic [2:0] lvl, string tag);
    @(negedge clk);
    src_i = s; cpu_imask_i = gm; cpu_ilvl_i = lm;
    push(cyc + 1, 1'b0, irq, nmi, id, lvl, tag);
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    bus_addr_i = a;
    #1;
    checks++;
    if (bus_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s: addr %0d got %h exp %h", tag, a, bus_rdata_o, exp);
    end
  endtask

  task automatic pin(logic v, logic irq, logic nmi, logic [2:0] lvl, string tag);
    @(negedge clk);
    nmi_i = v;
    push(cyc + 3, 1'b1, 1'b0, 1'b0, '0, '0, {tag, " early"});
    push(cyc + 4, 1'b0, irq, nmi, '0, lvl, tag);
    repeat (5) @(negedge clk);
  endtask

  task automatic ack(logic irq, logic [5:0] id, logic [2:0] lvl, string tag);
    @(negedge clk);
    nmi_ack_i = 1'b1;
    @(negedge clk);
    nmi_ack_i = 1'b0;
    push(cyc + 1, 1'b0, irq, 1'b0, id, lvl, tag);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [NS-1:0] b(int n);
    return NS'(1) << n;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    checks++;
    if (irq_o !== 1'b0 || irq_nmi_o !== 1'b0 || irq_id_o !== '0 || irq_lvl_o !== '0) begin
      errors++;
      $display("FAIL R1 outputs after reset: irq=%0b id=%0d lvl=%0d exp 0", irq_o, irq_id_o, irq_lvl_o);
    end
    rd_chk(4'd0, 16'h0000, "R1 prio reg 0");
    rd_chk(4'd10, 16'h0000, "R1 prio reg 10");
    rd_chk(CTRL_A, 16'h0000, "R1 ctrl");

    // R2 priority words
    wr(4'd0, 16'hF531);   // src0=1 src1=3 src2=5 src3=7, bit15 spare
    wr(4'd1, 16'h0005);   // src4=5
    wr(4'd10, 16'h0246);  // src40=6 src41=4 src42=2 src43=0
    rd_chk(4'd0, 16'hF531, "R2 reg 0 readback");
    rd_chk(4'd10, 16'h0246, "R2 reg 10 readback");
    rd_chk(4'd12, 16'h0000, "R2 unmapped addr");

    // R4 global scheme
    step(b(2) | b(41), 1'b0, 3'd7, 1'b1, 1'b0, 6'd2, 3'd5, "R4 lowest index wins");
    step(b(43), 1'b0, 3'd7, 1'b1, 1'b0, 6'd43, 3'd0, "R4 level 0 still accepted");
    step(b(2) | b(41), 1'b1, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R4 global mask blocks");
    step('0, 1'b0, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R11 idle outputs");

    // R5/R6 level scheme
    wr(CTRL_A, 16'h0002);
    rd_chk(CTRL_A, 16'h0002, "R3 ctrl level mode readback");
    step(b(1) | b(2) | b(40), 1'b1, 3'd0, 1'b1, 1'b0, 6'd40, 3'd6, "R6 highest level wins");
    step(b(1) | b(2) | b(40), 1'b0, 3'd6, 1'b0, 1'b0, 6'd0, 3'd0, "R5 mask 6 blocks levels <=6");
    step(b(3) | b(40), 1'b0, 3'd7, 1'b1, 1'b0, 6'd3, 3'd7, "R5 level 7 passes mask 7");
    step(b(40) | b(41), 1'b0, 3'd4, 1'b1, 1'b0, 6'd40, 3'd6, "R5 strict compare");
    step(b(41), 1'b0, 3'd4, 1'b0, 1'b0, 6'd0, 3'd0, "R5 equal level rejected");
    step(b(43), 1'b0, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R5 level 0 never accepted");
    step(b(2) | b(4), 1'b0, 3'd0, 1'b1, 1'b0, 6'd2, 3'd5, "R6 tie lowest index");

    // R7 prohibited modes
    wr(CTRL_A, 16'h0003);
    rd_chk(CTRL_A, 16'h0003, "R3 prohibited mode 11 reads back");
    step(b(2) | b(40), 1'b0, 3'd7, 1'b1, 1'b0, 6'd2, 3'd5, "R7 mode 11 acts global");
    step(b(2) | b(40), 1'b1, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R7 mode 11 global mask");
    wr(CTRL_A, 16'h0001);
    step(b(2) | b(40), 1'b0, 3'd7, 1'b1, 1'b0, 6'd2, 3'd5, "R7 mode 01 acts global");

    // R3 spare bits
    wr(CTRL_A, 16'hFFFA);
    rd_chk(CTRL_A, 16'h00FA, "R3 spare ctrl bits");
    step(b(2) | b(40), 1'b0, 3'd0, 1'b1, 1'b0, 6'd40, 3'd6, "R3 mode field with spares set");
    wr(CTRL_A, 16'h0000);
    step('0, 1'b0, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R11 idle after ctrl clear");

    // R8/R9/R10 falling-edge select
    pin(1'b1, 1'b0, 1'b0, 3'd0, "R8 rising ignored with falling select");
    pin(1'b0, 1'b1, 1'b1, 3'd7, "R8 falling edge raises nmi");
    step(b(2), 1'b0, 3'd0, 1'b1, 1'b1, 6'd0, 3'd7, "R10 nmi beats maskable");
    step(b(2), 1'b0, 3'd0, 1'b1, 1'b1, 6'd0, 3'd7, "R9 nmi sticky");
    ack(1'b1, 6'd2, 3'd5, "R9 ack clears nmi");

    // R8 rising-edge select
    wr(CTRL_A, 16'h0004);
    step('0, 1'b0, 3'd0, 1'b0, 1'b0, 6'd0, 3'd0, "R11 idle before rising test");
    pin(1'b1, 1'b1, 1'b1, 3'd7, "R8 rising edge raises nmi");
    ack(1'b0, 6'd0, 3'd0, "R9 ack clears rising nmi");
    pin(1'b0, 1'b0, 1'b0, 3'd0, "R8 falling ignored with rising select");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 scoreboard left %0d items exp 0", q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule